// File: doc/BRIEF.md
# Level-Sensitive 32-Source Interrupt Collector

This block gathers thirty-two level-sensitive interrupt lines into one status word, masks that word with a software-owned enable word, and drives a single request line toward the processor. Software reaches the block through a small synchronous register port made of an address, a write strobe, write data and combinational read data. Four 32-bit registers are decoded. The raw status register clears on write-one. A second alias of status takes a whole new word on write. The enable register is read/write. A masked view returns status AND enable and cannot be written.

Each status bit follows its input line. An asserted line sets its bit on every clock and keeps it set, even against a software clear. A falling line clears its bit. Between those two events, software may clear the bit, or set it through the replacement alias. The request output is registered and follows the masked status one clock later.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: While reset is asserted, status and enable read as zero and the request output is low.
- R2: Source line i maps to bit i (value 1 << i). At every clock edge where line i is high, status bit i becomes 1, and it stays 1 while the line stays high.
- R3: At a clock edge where line i was high on the previous edge and is now low, status bit i becomes 0. This clear wins over any register write in the same cycle.
- R4: A write to offset 0x0 clears each status bit whose write-data bit is 1 and keeps the rest. A bit whose line is high in that cycle stays 1.
- R5: A write to offset 0x4 replaces the status word with the write data, apart from the bits named in R2 and R3.
- R6: A write to offset 0x8 replaces all 32 enable bits. A read of 0x8 returns the enable word.
- R7: A read of offset 0xC returns status AND enable. A write to 0xC changes neither status nor enable.
- R8: Reads of offset 0x0 and of offset 0x4 both return the raw status word.
- R9: Any offset other than 0x0, 0x4, 0x8 and 0xC reads as zero, and writes to it change nothing.
- R10: The request output is high one clock after any edge that leaves status AND enable nonzero, and low one clock after any edge that leaves it zero.
- R11: Read data is combinational. In any cycle it shows the register selected by the address in that cycle, as held after the last clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 32 | Level interrupt lines, synchronous to clk |
| reg_addr_i | input | 4 | Byte offset of the register accessed |
| reg_we_i | input | 1 | Write strobe, one write per high cycle |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed register |
| cpu_irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The bench goes after the clear-versus-line race. If a software clear beat a held line, a live interrupt would vanish from status while its source still waits for service. The same cycle is also driven with a falling line plus a replacement write that sets the bit. A design that let the write win would leave a stale bit raised after the source went quiet. Other targets are writes to the masked view and to unmapped offsets, which a careless decoder would let fall through into status or enable. The request's single-cycle lag is also checked: an unregistered output would lead the model by one clock, and a doubly registered one would trail it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned OFF_STAT = 32'h0;
    localparam int unsigned OFF_SET  = 32'h4;
    localparam int unsigned OFF_EN   = 32'h8;
    localparam int unsigned OFF_MASK = 32'hC;

    typedef enum logic [1:0] {
        RD_ZERO = 2'd0,
        RD_STAT = 2'd1,
        RD_EN   = 2'd2,
        RD_MASK = 2'd3
    } irqc_rd_e;

    typedef struct packed {
        logic clr;
        logic set;
        logic en;
    } irqc_wr_t;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    output irqc_wr_t          wr_o,
    output irqc_rd_e          rd_o
);

    logic hit_stat;
    logic hit_set;
    logic hit_en;
    logic hit_mask;

    always_comb begin
        hit_stat = (addr_i == ADDR_W'(OFF_STAT));
        hit_set  = (addr_i == ADDR_W'(OFF_SET));
        hit_en   = (addr_i == ADDR_W'(OFF_EN));
        hit_mask = (addr_i == ADDR_W'(OFF_MASK));

        wr_o.clr = we_i & hit_stat;
        wr_o.set = we_i & hit_set;
        wr_o.en  = we_i & hit_en;

        if (hit_stat || hit_set) begin
            rd_o = RD_STAT;
        end else if (hit_en) begin
            rd_o = RD_EN;
        end else if (hit_mask) begin
            rd_o = RD_MASK;
        end else begin
            rd_o = RD_ZERO;
        end
    end

endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  irqc_wr_t           wr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] status_o,
    output logic [NUM_SRC-1:0] enable_o,
    output logic [NUM_SRC-1:0] prev_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] status;
        logic [NUM_SRC-1:0] enable;
        logic [NUM_SRC-1:0] prev;
    } rf_t;

    rf_t rf_d;
    rf_t rf_q;

    logic [NUM_SRC-1:0] stat_nxt;

    // Per-bit status update: software first, then line level, falling line last.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic sw_val;
        logic fell;

        always_comb begin
            if (wr_i.set) begin
                sw_val = wdata_i[i];
            end else if (wr_i.clr) begin
                sw_val = rf_q.status[i] & ~wdata_i[i];
            end else begin
                sw_val = rf_q.status[i];
            end
            fell        = rf_q.prev[i] & ~src_i[i];
            stat_nxt[i] = (sw_val | src_i[i]) & ~fell;
        end
    end

    always_comb begin
        rf_d        = rf_q;
        rf_d.status = stat_nxt;
        rf_d.prev   = src_i;
        if (wr_i.en) begin
            rf_d.enable = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign status_o = rf_q.status;
    assign enable_o = rf_q.enable;
    assign prev_o   = rf_q.prev;

endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  irqc_rd_e           sel_i,
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [NUM_SRC-1:0] enable_i,
    output logic [NUM_SRC-1:0] rdata_o
);

    always_comb begin
        unique case (sel_i)
            RD_STAT: rdata_o = status_i;
            RD_EN:   rdata_o = enable_i;
            RD_MASK: rdata_o = status_i & enable_i;
            default: rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irqc_reqgen.sv
module irqc_reqgen #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [NUM_SRC-1:0] enable_i,
    output logic               irq_o
);

    typedef struct packed {
        logic irq;
    } req_t;

    req_t req_d;
    req_t req_q;

    always_comb begin
        req_d     = req_q;
        req_d.irq = |(status_i & enable_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign irq_o = req_q.irq;

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic               reg_we_i,
    input  logic [NUM_SRC-1:0] reg_wdata_i,
    output logic [NUM_SRC-1:0] reg_rdata_o,
    output logic               cpu_irq_o
);

    irqc_wr_t           wr_strb;
    irqc_rd_e           rd_sel;
    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] prev_q;

    irqc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (reg_addr_i),
        .we_i   (reg_we_i),
        .wr_o   (wr_strb),
        .rd_o   (rd_sel)
    );

    irqc_regfile #(.NUM_SRC(NUM_SRC)) u_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (irq_src_i),
        .wr_i     (wr_strb),
        .wdata_i  (reg_wdata_i),
        .status_o (stat_q),
        .enable_o (en_q),
        .prev_o   (prev_q)
    );

    irqc_rdmux #(.NUM_SRC(NUM_SRC)) u_rdmux (
        .sel_i    (rd_sel),
        .status_i (stat_q),
        .enable_i (en_q),
        .rdata_o  (reg_rdata_o)
    );

    irqc_reqgen #(.NUM_SRC(NUM_SRC)) u_reqgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (stat_q),
        .enable_i (en_q),
        .irq_o    (cpu_irq_o)
    );

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic               we_i,
    input logic [NUM_SRC-1:0] wdata_i,
    input logic [NUM_SRC-1:0] rdata_i,
    input logic               irq_i,
    input logic [NUM_SRC-1:0] stat_q,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] prev_q
);

    logic a_stat;
    logic a_set;
    logic a_en;
    logic a_mask;
    logic a_none;

    assign a_stat = (addr_i == ADDR_W'(0));
    assign a_set  = (addr_i == ADDR_W'(4));
    assign a_en   = (addr_i == ADDR_W'(8));
    assign a_mask = (addr_i == ADDR_W'(12));
    assign a_none = !(a_stat || a_set || a_en || a_mask);

    AST_RST_QUIET: assert property (@(posedge clk)
        !rst_n |-> (stat_q == '0 && en_q == '0 && !irq_i)); // R1

    AST_LINE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i != '0) |=> ((stat_q & $past(src_i)) == $past(src_i))); // R2

    AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((prev_q & ~src_i) != '0) |=> ((stat_q & $past(prev_q & ~src_i)) == '0)); // R3

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && a_stat) |=> ((stat_q & $past(wdata_i & ~src_i)) == '0)); // R4

    AST_SET_REPLACES: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && a_set && src_i == '0 && prev_q == '0) |=> (stat_q == $past(wdata_i))); // R5

    AST_EN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && a_en) |=> (en_q == $past(wdata_i))); // R6

    AST_MASK_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        a_mask |-> (rdata_i == (stat_q & en_q))); // R7

    AST_RAW_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        (a_stat || a_set) |-> (rdata_i == stat_q)); // R8

    AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        a_none |-> (rdata_i == '0)); // R9

    AST_HOLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (a_none || a_mask) && src_i == '0 && prev_q == '0)
        |=> (stat_q == $past(stat_q) && en_q == $past(en_q))); // R9

    AST_REQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & en_q) != '0) |=> irq_i); // R10

    AST_REQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & en_q) == '0) |=> !irq_i); // R10

endmodule

bind lvl_irq_ctrl irqc_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_i   (irq_src_i),
    .addr_i  (reg_addr_i),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .rdata_i (reg_rdata_o),
    .irq_i   (cpu_irq_o),
    .stat_q  (stat_q),
    .en_q    (en_q),
    .prev_q  (prev_q)
);

// File: tb/lvl_irq_ctrl_tb.sv
module lvl_irq_ctrl_tb;

    localparam int N  = 32;
    localparam int AW = 4;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src   = '0;
    logic [AW-1:0] addr  = '0;
    logic          we    = 1'b0;
    logic [N-1:0]  wd    = '0;
    logic [N-1:0]  rdata;
    logic          irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // behavioural reference state
    logic [N-1:0] m_st   = '0;
    logic [N-1:0] m_en   = '0;
    logic [N-1:0] m_prev = '0;
    logic         m_irq  = 1'b0;

    always #4 clk = ~clk;

    lvl_irq_ctrl #(.NUM_SRC(N), .ADDR_W(AW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_src_i   (src),
        .reg_addr_i  (addr),
        .reg_we_i    (we),
        .reg_wdata_i (wd),
        .reg_rdata_o (rdata),
        .cpu_irq_o   (irq)
    );

    function automatic logic [N-1:0] m_read(logic [AW-1:0] a);
        case (a)
            4'h0, 4'h4: return m_st;
            4'h8:       return m_en;
            4'hC:       return m_st & m_en;
            default:    return '0;
        endcase
    endfunction

    task automatic check(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock: drive, compare against the model, then advance the model at the edge.
    task automatic step(string tag, logic [N-1:0] s, logic [AW-1:0] a, logic w, logic [N-1:0] d);
        logic         nirq;
        logic [N-1:0] sw;
        @(negedge clk);
        src  = s;
        addr = a;
        we   = w;
        wd   = d;
        #1;
        check(tag, "rdata", rdata, m_read(a));
        check(tag, "irq R10", {31'b0, irq}, {31'b0, m_irq});
        @(posedge clk);
        if (!rst_n) begin
            m_st = '0; m_en = '0; m_prev = '0; m_irq = 1'b0;
        end else begin
            nirq = |(m_st & m_en);
            sw   = m_st;
            if (w && a == 4'h0) sw = m_st & ~d;
            if (w && a == 4'h4) sw = d;
            if (w && a == 4'h8) m_en = d;
            m_st   = (sw | s) & ~(m_prev & ~s);
            m_prev = s;
            m_irq  = nirq;
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R10 watchdog: got no completion expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state, with a write attempted while held in reset
        step("R1", '0, 4'h0, 1'b0, '0);
        step("R1", '0, 4'h8, 1'b1, 32'hFFFF_FFFF);
        step("R1", '0, 4'h8, 1'b0, '0);
        step("R1", '0, 4'hC, 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: enable load and readback
        step("R6", '0, 4'h8, 1'b1, 32'hFFFF_0000);
        step("R6", '0, 4'h8, 1'b0, '0);
        // R2: lines 0 and 16 raised and held; R10 lag observed
        step("R2", 32'h0001_0001, 4'h0, 1'b0, '0);
        step("R2", 32'h0001_0001, 4'h0, 1'b0, '0);
        step("R10", 32'h0001_0001, 4'hC, 1'b0, '0);
        // R4: clear while lines held - bits must stay
        step("R4", 32'h0001_0001, 4'h0, 1'b1, 32'h0001_0001);
        step("R4", 32'h0001_0001, 4'h0, 1'b0, '0);
        // R3: lines fall, bits clear, request drops a cycle later
        step("R3", '0, 4'h0, 1'b0, '0);
        step("R3", '0, 4'h0, 1'b0, '0);
        step("R10", '0, 4'hC, 1'b0, '0);
        // R5: whole-word replacement twice
        step("R5", '0, 4'h4, 1'b1, 32'hA5A5_0F0F);
        step("R8", '0, 4'h4, 1'b0, '0);
        step("R5", '0, 4'h4, 1'b1, 32'h0000_0001);
        step("R8", '0, 4'h0, 1'b0, '0);
        // R4: software clear with no line held
        step("R4", '0, 4'h0, 1'b1, 32'h0000_0001);
        step("R4", '0, 4'h0, 1'b0, '0);
        // R7: masked view and ignored write
        step("R5", '0, 4'h4, 1'b1, 32'hF00F_F00F);
        step("R7", '0, 4'hC, 1'b1, 32'hFFFF_FFFF);
        step("R7", '0, 4'h0, 1'b0, '0);
        step("R7", '0, 4'h8, 1'b0, '0);
        // R9: holes read zero and absorb writes
        for (int k = 0; k < 16; k++) begin
            if (k % 4 != 0) step("R9", '0, AW'(k), 1'b1, 32'hFFFF_FFFF);
        end
        step("R9", '0, 4'h0, 1'b0, '0);
        step("R9", '0, 4'h8, 1'b0, '0);
        // R3: falling line beats a same-cycle replacement that sets it
        step("R3", 32'h0000_0020, 4'h8, 1'b1, 32'hFFFF_FFFF);
        step("R3", '0, 4'h4, 1'b1, 32'h0000_0020);
        step("R3", '0, 4'h0, 1'b0, '0);
        step("R10", '0, 4'hC, 1'b0, '0);

        // R11: mixed traffic, every cycle compared
        begin
            logic [N-1:0] s;
            s = '0;
            for (int k = 0; k < 3000; k++) begin
                if ($urandom_range(3) == 0) s = $urandom & $urandom;
                step("R11", s, AW'($urandom_range(15)), 1'($urandom_range(1)), $urandom);
            end
        end
        step("R11", '0, 4'h0, 1'b0, '0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule